// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers the event flags of a serial bus controller into a sticky status register and turns them into a single interrupt request. Each event arrives as a one-cycle pulse and latches its status bit. Software reads the status in two views: the raw view, which shows every latched event plus the live bus-busy level, and the masked view, which shows only the events whose enable bit is set. Software clears an event by writing a one to its bit.

The enable mask is never written directly. One register address sets enable bits wherever a one is written. A second address clears them wherever a one is written. A driver can therefore change one interrupt source without a read-modify-write sequence. The interrupt output is registered and rises when any latched event is also enabled.

Register map (16-bit data, 3-bit address): 0 = raw status (read, write-one-to-clear), 1 = masked status (read, write-one-to-clear), 2 = enable set (reads the mask), 3 = enable clear (reads the mask). Addresses 4 to 7 read as zero and ignore writes.

Top module: `isr_ctrl_top`

## Requirements
- R1: After a synchronous reset, every status bit, every enable bit, the interrupt output and the read data are zero.
- R2: A one-cycle pulse on an event input sets the matching status bit, and that bit stays set until software clears it.
- R3: A write to address 0 or address 1 clears each status bit whose data bit is one. Status bits written with zero keep their value.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the event wins and the bit stays set. Other bits in the same write still clear.
- R5: A write to address 2 sets each enable bit whose data bit is one. All other enable bits keep their value. Addresses 2 and 3 read back the mask.
- R6: A write to address 3 clears each enable bit whose data bit is one, so writing 0xFFFF disables every source. Writes to the mask never alter the status bits.
- R7: Address 1 reads the raw event status ANDed with the enable mask.
- R8: Bit 12 of the raw view is the live bus-busy input. It is not latched, it never appears in the masked view, and it never raises the interrupt.
- R9: The interrupt output is the OR of all masked status bits. It is registered and changes one clock after the state that causes it.
- R10: Event and enable bit positions are: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 receive draining, 6 transmit draining.
- R11: Read data appears on the clock after the read strobe and holds while no read is strobed. Addresses 4 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 7 | One-cycle event pulses, positions as in R10 |
| bus_busy_i | input | 1 | Live bus-busy level |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
An event pulse and a clearing write can land on the same status bit in the same cycle. This is the collision case that R4 settles in favour of the event. The bench provokes it by driving the event input and a write-one-to-clear on the same falling edge, so that both are captured at one rising edge. A second bit, cleared by the same write without a coinciding event, is included. The raw view read back afterwards must show the colliding bit still set and the other bit gone.

// File: rtl/isr_pkg.sv
package isr_pkg;
  typedef enum logic [2:0] {
    ADR_RAW    = 3'd0,
    ADR_MASKED = 3'd1,
    ADR_EN_SET = 3'd2,
    ADR_EN_CLR = 3'd3
  } isr_addr_e;

  localparam int EVT_ARB_LOST = 0;
  localparam int EVT_NO_ACK   = 1;
  localparam int EVT_ACC_RDY  = 2;
  localparam int EVT_RX_RDY   = 3;
  localparam int EVT_TX_RDY   = 4;
  localparam int EVT_RX_DRAIN = 5;
  localparam int EVT_TX_DRAIN = 6;
endpackage

// File: rtl/isr_status_bank.sv
module isr_status_bank #(
  parameter int N_EVT = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             clr_en_i,
  input  logic [N_EVT-1:0] clr_bits_i,
  output logic [N_EVT-1:0] status_o
);
  for (genvar b = 0; b < N_EVT; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                            status_o[b] <= 1'b0;
      else if (evt_i[b])                  status_o[b] <= 1'b1;
      else if (clr_en_i && clr_bits_i[b]) status_o[b] <= 1'b0;
    end
  end

  AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((status_o & $past(evt_i)) == $past(evt_i))); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clr_en_i |=> ((status_o & $past(clr_bits_i & ~evt_i)) == '0)); // R3
  AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    (clr_en_i && ((clr_bits_i & evt_i) != '0)) |=> ((status_o & $past(clr_bits_i & evt_i)) != '0)); // R4
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!clr_en_i && evt_i == '0) |=> $stable(status_o)); // R2
endmodule

// File: rtl/isr_enable_mask.sv
module isr_enable_mask #(
  parameter int N_EVT = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en_i,
  input  logic             clr_en_i,
  input  logic [N_EVT-1:0] bits_i,
  output logic [N_EVT-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst)           mask_o <= '0;
    else if (set_en_i) mask_o <= mask_o | bits_i;
    else if (clr_en_i) mask_o <= mask_o & ~bits_i;
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
    set_en_i |=> ((mask_o & $past(bits_i)) == $past(bits_i))); // R5
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
    (clr_en_i && !set_en_i) |=> ((mask_o & $past(bits_i)) == '0)); // R6
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!set_en_i && !clr_en_i) |=> $stable(mask_o)); // R5
endmodule

// File: rtl/isr_read_port.sv
module isr_read_port
  import isr_pkg::*;
#(
  parameter int N_EVT    = 7,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int BUSY_BIT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_EVT-1:0]  status_i,
  input  logic [N_EVT-1:0]  mask_i,
  input  logic              busy_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] raw_view, masked_view, mask_view, sel;

  always_comb begin
    raw_view           = '0;
    raw_view[N_EVT-1:0] = status_i;
    raw_view[BUSY_BIT] = busy_i;
    masked_view        = '0;
    masked_view[N_EVT-1:0] = status_i & mask_i;
    mask_view          = '0;
    mask_view[N_EVT-1:0] = mask_i;
    case (addr_i)
      ADR_RAW:                sel = raw_view;
      ADR_MASKED:             sel = masked_view;
      ADR_EN_SET, ADR_EN_CLR: sel = mask_view;
      default:                sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= sel;
  end

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_o)); // R11
  AST_MASKED_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == ADR_MASKED) |=> !rdata_o[BUSY_BIT]); // R8
endmodule

// File: rtl/isr_ctrl_top.sv
module isr_ctrl_top
  import isr_pkg::*;
#(
  parameter int N_EVT    = 7,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int BUSY_BIT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              bus_busy_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_rd_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [N_EVT-1:0] status, mask, wbits;
  logic             st_clr, en_set, en_clr, pending;

  assign wbits   = reg_wdata_i[N_EVT-1:0];
  assign st_clr  = reg_wr_i && (reg_addr_i == ADR_RAW || reg_addr_i == ADR_MASKED);
  assign en_set  = reg_wr_i && (reg_addr_i == ADR_EN_SET);
  assign en_clr  = reg_wr_i && (reg_addr_i == ADR_EN_CLR);
  assign pending = |(status & mask);

  isr_status_bank #(.N_EVT(N_EVT)) u_status (
    .clk(clk), .rst(rst), .evt_i(evt_i), .clr_en_i(st_clr),
    .clr_bits_i(wbits), .status_o(status)
  );

  isr_enable_mask #(.N_EVT(N_EVT)) u_mask (
    .clk(clk), .rst(rst), .set_en_i(en_set), .clr_en_i(en_clr),
    .bits_i(wbits), .mask_o(mask)
  );

  isr_read_port #(.N_EVT(N_EVT), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BUSY_BIT(BUSY_BIT)) u_read (
    .clk(clk), .rst(rst), .rd_en_i(reg_rd_i), .addr_i(reg_addr_i),
    .status_i(status), .mask_i(mask), .busy_i(bus_busy_i), .rdata_o(reg_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= pending;
  end

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (rst)
    pending |=> irq_o); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !pending |=> !irq_o); // R9
  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (status == '0 && mask == '0 && !irq_o)); // R1
endmodule

// File: tb/tb_isr_ctrl_top.sv
module tb_isr_ctrl_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [6:0]  evt;
  logic        busy;
  logic [2:0]  addr;
  logic        wr, rd;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_err = 0;

  always #4 clk = ~clk;

  isr_ctrl_top dut (
    .clk(clk), .rst(rst), .evt_i(evt), .bus_busy_i(busy), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rd_i(rd), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; evt = '0; busy = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input logic [6:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    do_reset();
    chk("R1 rdata", rdata, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0000);
    reg_read(3'd0, d); chk("R1 raw", d, 16'h0000);
    reg_read(3'd2, d); chk("R1 mask", d, 16'h0000);
  endtask

  task automatic t_sticky();
    logic [15:0] d;
    do_reset();
    pulse(7'h04);
    reg_read(3'd0, d); chk("R2 access ready latched", d, 16'h0004);
    repeat (5) @(negedge clk);
    reg_read(3'd0, d); chk("R2 stays set", d, 16'h0004);
    chk("R9 no irq while masked", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_enable();
    logic [15:0] d;
    do_reset();
    reg_write(3'd2, 16'h0018);
    reg_read(3'd2, d); chk("R5 R10 rx/tx ready enables", d, 16'h0018);
    reg_write(3'd2, 16'h0001);
    reg_read(3'd3, d); chk("R5 zeros keep bits", d, 16'h0019);
  endtask

  task automatic t_masked();
    logic [15:0] d;
    do_reset();
    reg_write(3'd2, 16'h0018);
    pulse(7'h0A);
    reg_read(3'd1, d); chk("R7 masked view", d, 16'h0008);
    reg_read(3'd0, d); chk("R7 raw view", d, 16'h000A);
    chk("R10 rx ready raises irq", {15'b0, irq}, 16'h0001);
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    do_reset();
    pulse(7'h7F);
    reg_write(3'd0, 16'h0005);
    reg_read(3'd0, d); chk("R3 clear via raw", d, 16'h007A);
    reg_write(3'd1, 16'h0002);
    reg_read(3'd0, d); chk("R3 clear via masked", d, 16'h0078);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    do_reset();
    pulse(7'h01);
    @(negedge clk);
    evt = 7'h10; addr = 3'd0; wdata = 16'h0011; wr = 1'b1;
    @(negedge clk);
    evt = '0; wr = 1'b0; wdata = '0;
    reg_read(3'd0, d); chk("R4 event wins collision", d, 16'h0010);
  endtask

  task automatic t_mask_clear();
    logic [15:0] d;
    do_reset();
    reg_write(3'd2, 16'h007F);
    pulse(7'h7F);
    @(negedge clk);
    chk("R9 irq all enabled", {15'b0, irq}, 16'h0001);
    reg_write(3'd3, 16'hFFFF);
    reg_read(3'd2, d); chk("R6 all disabled", d, 16'h0000);
    chk("R6 irq dropped", {15'b0, irq}, 16'h0000);
    reg_read(3'd0, d); chk("R6 status untouched", d, 16'h007F);
  endtask

  task automatic t_busy();
    logic [15:0] d;
    do_reset();
    reg_write(3'd2, 16'h007F);
    busy = 1'b1;
    reg_read(3'd0, d); chk("R8 busy in raw bit 12", d, 16'h1000);
    reg_read(3'd1, d); chk("R8 busy not masked view", d, 16'h0000);
    chk("R8 busy no irq", {15'b0, irq}, 16'h0000);
    busy = 1'b0;
    reg_read(3'd0, d); chk("R8 busy not latched", d, 16'h0000);
  endtask

  task automatic t_irq_timing();
    do_reset();
    reg_write(3'd2, 16'h0010);
    pulse(7'h10);
    chk("R9 irq one cycle later (not yet)", {15'b0, irq}, 16'h0000);
    @(negedge clk);
    chk("R9 irq risen", {15'b0, irq}, 16'h0001);
    reg_write(3'd0, 16'h0010);
    chk("R9 irq still high on clear edge", {15'b0, irq}, 16'h0001);
    @(negedge clk);
    chk("R9 irq falls", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    do_reset();
    pulse(7'h7F);
    reg_write(3'd5, 16'hFFFF);
    reg_read(3'd0, d); chk("R11 unmapped write ignored", d, 16'h007F);
    reg_read(3'd7, d); chk("R11 unmapped reads zero", d, 16'h0000);
    reg_read(3'd0, d);
    repeat (3) @(negedge clk);
    chk("R11 rdata holds", rdata, 16'h007F);
  endtask

  initial begin
    rst = 1'b1; evt = '0; busy = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    t_reset();
    t_sticky();
    t_enable();
    t_masked();
    t_w1c();
    t_collide();
    t_mask_clear();
    t_busy();
    t_irq_timing();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule